// File: doc/BRIEF.md
# Timed-Unlock Sleep and Brown-Out Control Registers

This block is a pair of byte-wide registers on a microcontroller's I/O bus. It also contains the small sequencer that lets software turn off the brown-out detector for one sleep period. The general control register stores these fields:

- a pull-up disable bit;
- a sleep-enable bit;
- a two-bit sleep-mode field;
- a two-bit interrupt-sense field.

The block drives each field to an output. A strobe from the CPU marks the execution of a sleep instruction. The block answers it with a sleep request only when sleep is enabled.

The brown-out register exposes two live bits, a "detector off in sleep" flag and its enable. Software cannot set the flag with one write. It first writes both bits as 1 to arm the sequencer. A second write must then follow within a short window, with the flag at 1 and the enable at 0. The flag then reads 1, but it becomes usable only after a fixed delay. It stays usable for a fixed number of cycles and then clears without any software action. A sleep strobe that arrives while the flag is usable, with sleep enabled, switches the detector off. The detector stays off until a wake-up pulse arrives.

The sequencer is a state machine with four states:

- `UL_IDLE` is the rest state.
- `UL_ARMED` is the window after the arming write.
- `UL_PEND` is the delay before the flag takes effect.
- `UL_LIVE` is the period in which the flag is usable.

Its transitions are as follows:

- ARM: `UL_IDLE` to `UL_ARMED` on a write of 0b11.
- COMMIT: `UL_ARMED` to `UL_PEND` on a write of 0b10.
- ABORT: `UL_ARMED` to `UL_IDLE` on any other write to the brown-out register.
- EXPIRE: `UL_ARMED` to `UL_IDLE` when the window elapses.
- MATURE: `UL_PEND` to `UL_LIVE` when the delay elapses.
- LAPSE: `UL_LIVE` to `UL_IDLE` when the hold elapses.

The output machine has two states, `GT_AWAKE` and `GT_BODOFF`. It moves from `GT_AWAKE` to `GT_BODOFF` on a qualified sleep strobe (SLEEP_OFF) and back on a wake pulse (WAKE).

Top module: `bodslp_ctrl`

## Requirements
- R1: After reset, both registers read 0x00 and every output is 0.
- R2: A write to address 0x35 stores data bits 6, 5, 4..3 and 1..0, and bits 7 and 2 read 0. On the outputs, bit 6 drives `pullup_off`, bit 5 drives `sleep_en`, bits 4..3 drive `sleep_mode` and bits 1..0 drive `int_sense`.
- R3: At address 0x30, bits 7..2 always read 0. Any other address reads 0x00, and a write to it changes nothing.
- R4: A write of 0b11 to bits 1..0 at address 0x30, made while the sequencer rests, arms it. From the next cycle the register reads 0x03.
- R5: Suppose a write of 0b10 at address 0x30 is made in any of the four cycles after the arming write. From the next cycle the register reads 0x02.
- R6: The set is lost in two cases: the completing write comes in the fifth cycle after arming or later, or a different value is written to 0x30 inside the window. In either case the register reads 0x00 from the cycle after the window expires or after the mismatching write.
- R7: A write of 0b10 to 0x30 without a preceding arming write has no effect, and the register keeps reading 0x00.
- R8: Take the completing write in cycle j. The flag reads 1 in cycles j+1 through j+6. It is usable for sleep only in cycles j+4 through j+6, and it reads 0 from cycle j+7.
- R9: `sleep_req` equals `sleep_op` AND the sleep-enable bit, in the same cycle.
- R10: `bod_off` rises on the clock edge that ends a cycle meeting three conditions: `sleep_op` is 1, sleep is enabled, and the flag is usable. A sleep strobe at any other time leaves `bod_off` at 0.
- R11: Once `bod_off` is 1, it stays 1 until `wake` is 1, and it falls on that clock edge.
- R12: Writes to 0x30 while the flag is pending or usable are ignored, and the timing of R8 still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | I/O register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| sleep_op | input | 1 | Sleep instruction strobe from the CPU |
| wake | input | 1 | Wake-up pulse |
| sleep_en | output | 1 | Sleep-enable field |
| sleep_mode | output | 2 | Sleep-mode field |
| pullup_off | output | 1 | Pull-up disable field |
| int_sense | output | 2 | Interrupt-sense field |
| sleep_req | output | 1 | Sleep request to the power manager |
| bod_off | output | 1 | Brown-out detector off during sleep |

## Verification
A wrong sequencer state shows up at the brown-out register readback no later than the cycle after the write that caused it, because the flag and enable bits are live views of the state. An off-by-one error in the window, delay or hold counter moves the first or last cycle in which the readback or `bod_off` changes. The bench therefore sweeps the offset of the completing write and of the sleep strobe cycle by cycle across each boundary. A fault in the general register shows up on its field outputs and readback in the cycle after the write, so all 256 data values are swept.

// File: rtl/bodslp_pkg.sv
package bodslp_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] BOD_ADDR = 6'h30;
    localparam logic [ADDR_W-1:0] MCU_ADDR = 6'h35;

    // Writable bits of the general control register
    localparam logic [DATA_W-1:0] MCU_MASK = 8'h7B;

    // Bit 1 = flag, bit 0 = enable
    localparam logic [1:0] PAT_ARM    = 2'b11;
    localparam logic [1:0] PAT_COMMIT = 2'b10;

    typedef enum logic [1:0] {
        UL_IDLE,
        UL_ARMED,
        UL_PEND,
        UL_LIVE
    } ul_state_t;

    typedef enum logic {
        GT_AWAKE,
        GT_BODOFF
    } gt_state_t;

endpackage

// File: rtl/bodslp_unlock.sv
module bodslp_unlock
    import bodslp_pkg::*;
#(
    parameter int WINDOW = 4,
    parameter int DELAY  = 3,
    parameter int HOLD   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [1:0] wr_bits,
    output logic       flag_rd,
    output logic       enab_rd,
    output logic       live
);

    localparam int CNT_MAX = (WINDOW > DELAY) ? ((WINDOW > HOLD) ? WINDOW : HOLD)
                                              : ((DELAY > HOLD) ? DELAY : HOLD);
    localparam int CW = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
    localparam logic [CW-1:0] WIN_LAST = CW'(WINDOW - 1);
    localparam logic [CW-1:0] DLY_LAST = CW'(DELAY - 1);
    localparam logic [CW-1:0] HLD_LAST = CW'(HOLD - 1);

    ul_state_t     st, st_n;
    logic [CW-1:0] cnt, cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= UL_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            UL_IDLE: begin
                if (wr_hit && wr_bits == PAT_ARM) begin       // ARM
                    st_n  = UL_ARMED;
                    cnt_n = '0;
                end
            end
            UL_ARMED: begin
                if (wr_hit) begin
                    cnt_n = '0;
                    if (wr_bits == PAT_COMMIT) st_n = UL_PEND; // COMMIT
                    else                       st_n = UL_IDLE; // ABORT
                end else if (cnt == WIN_LAST) begin           // EXPIRE
                    st_n  = UL_IDLE;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            UL_PEND: begin
                if (cnt == DLY_LAST) begin                    // MATURE
                    st_n  = UL_LIVE;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            UL_LIVE: begin
                if (cnt == HLD_LAST) begin                    // LAPSE
                    st_n  = UL_IDLE;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: begin
                st_n  = UL_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    always_comb begin
        flag_rd = (st != UL_IDLE);
        enab_rd = (st == UL_ARMED);
        live    = (st == UL_LIVE);
    end

    AST_PEND_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == UL_PEND && $past(st) != UL_PEND) |-> $past(st) == UL_ARMED); // R5
    AST_LIVE_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == UL_LIVE && $past(st) != UL_LIVE) |-> $past(st) == UL_PEND); // R8
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == UL_ARMED) |-> cnt <= WIN_LAST); // R6
    AST_PEND_IGNORES_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == UL_PEND && cnt != DLY_LAST) |=> st == UL_PEND); // R12

endmodule

// File: rtl/bodslp_mcureg.sv
module bodslp_mcureg
    import bodslp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q,
    output logic              pullup_off,
    output logic              sleep_en,
    output logic [1:0]        sleep_mode,
    output logic [1:0]        int_sense
);

    logic [DATA_W-1:0] r;

    always_ff @(posedge clk) begin
        if (!rst_n)      r <= '0;
        else if (wr_hit) r <= wdata & MCU_MASK;
    end

    always_comb begin
        q          = r;
        pullup_off = r[6];
        sleep_en   = r[5];
        sleep_mode = r[4:3];
        int_sense  = r[1:0];
    end

    AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (r[7] == 1'b0 && r[2] == 1'b0)); // R2

endmodule

// File: rtl/bodslp_gate.sv
module bodslp_gate
    import bodslp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_op,
    input  logic sleep_en,
    input  logic live,
    input  logic wake,
    output logic sleep_req,
    output logic bod_off
);

    gt_state_t st, st_n;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= GT_AWAKE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            GT_AWAKE:  if (!wake && sleep_op && sleep_en && live) st_n = GT_BODOFF; // SLEEP_OFF
            GT_BODOFF: if (wake) st_n = GT_AWAKE;                                    // WAKE
            default:   st_n = GT_AWAKE;
        endcase
    end

    always_comb begin
        sleep_req = sleep_op & sleep_en;
        bod_off   = (st == GT_BODOFF);
    end

    AST_OFF_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bod_off) |-> $past(sleep_op && sleep_en && live)); // R10
    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !bod_off); // R11
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bod_off && !wake) |=> bod_off); // R11

endmodule

// File: rtl/bodslp_ctrl.sv
module bodslp_ctrl
    import bodslp_pkg::*;
#(
    parameter int WINDOW = 4,
    parameter int DELAY  = 3,
    parameter int HOLD   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sleep_op,
    input  logic              wake,
    output logic              sleep_en,
    output logic [1:0]        sleep_mode,
    output logic              pullup_off,
    output logic [1:0]        int_sense,
    output logic              sleep_req,
    output logic              bod_off
);

    logic              bod_hit, mcu_hit;
    logic              flag_rd, enab_rd, live;
    logic [DATA_W-1:0] mcu_q;

    assign bod_hit = bus_we && (bus_addr == BOD_ADDR);
    assign mcu_hit = bus_we && (bus_addr == MCU_ADDR);

    bodslp_unlock #(.WINDOW(WINDOW), .DELAY(DELAY), .HOLD(HOLD)) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (bod_hit),
        .wr_bits (bus_wdata[1:0]),
        .flag_rd (flag_rd),
        .enab_rd (enab_rd),
        .live    (live)
    );

    bodslp_mcureg u_mcureg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (mcu_hit),
        .wdata      (bus_wdata),
        .q          (mcu_q),
        .pullup_off (pullup_off),
        .sleep_en   (sleep_en),
        .sleep_mode (sleep_mode),
        .int_sense  (int_sense)
    );

    bodslp_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_op  (sleep_op),
        .sleep_en  (sleep_en),
        .live      (live),
        .wake      (wake),
        .sleep_req (sleep_req),
        .bod_off   (bod_off)
    );

    always_comb begin
        if (bus_addr == BOD_ADDR)      bus_rdata = {6'b0, flag_rd, enab_rd};
        else if (bus_addr == MCU_ADDR) bus_rdata = mcu_q;
        else                           bus_rdata = '0;
    end

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> sleep_en); // R9
    AST_BOD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == BOD_ADDR) |-> bus_rdata[7:2] == 6'b0); // R3

endmodule

// File: tb/bodslp_ctrl_test.sv
module bodslp_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] A_BOD = 6'h30;
    localparam logic [5:0] A_MCU = 6'h35;
    localparam logic [5:0] A_OTH = 6'h31;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       sleep_op, wake;
    logic       sleep_en, pullup_off, sleep_req, bod_off;
    logic [1:0] sleep_mode, int_sense;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bodslp_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_op(sleep_op),
        .wake(wake), .sleep_en(sleep_en), .sleep_mode(sleep_mode),
        .pullup_off(pullup_off), .int_sense(int_sense),
        .sleep_req(sleep_req), .bod_off(bod_off)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle's inputs at the falling edge, wait past the rising edge.
    task automatic step(input logic we, input logic [5:0] a, input logic [7:0] d,
                        input logic s, input logic w);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; sleep_op = s; wake = w;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, A_BOD, 8'h00, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_we = 0; bus_addr = A_BOD; bus_wdata = 0; sleep_op = 0; wake = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        idle(1);
        chk("R1 bod reg", bus_rdata, 8'h00);
        chk("R1 outputs", {2'b0, sleep_en, sleep_mode, pullup_off, int_sense}, 8'h00);
        chk("R1 bod_off", {7'b0, bod_off}, 8'h00);
        step(1'b0, A_MCU, 8'h00, 1'b0, 1'b0);
        chk("R1 mcu reg", bus_rdata, 8'h00);

        // R2 exhaustive data sweep of the general register
        for (int v = 0; v < 256; v++) begin
            step(1'b1, A_MCU, 8'(v), 1'b0, 1'b0);
            chk("R2 readback", bus_rdata, 8'(v) & 8'h7B);
            chk("R2 fields", {2'b0, sleep_en, sleep_mode, pullup_off, int_sense},
                {2'b0, 1'(v >> 5), 2'(v >> 3), 1'(v >> 6), 2'(v)});
        end

        // R3 other address: write ignored, reads zero
        step(1'b1, A_MCU, 8'h20, 1'b0, 1'b0);
        step(1'b1, A_OTH, 8'hFF, 1'b0, 1'b0);
        chk("R3 other addr read", bus_rdata, 8'h00);
        step(1'b0, A_MCU, 8'h00, 1'b0, 1'b0);
        chk("R3 mcu untouched", bus_rdata, 8'h20);
        step(1'b1, A_BOD, 8'hFC, 1'b0, 1'b0);
        chk("R3 bod high bits", bus_rdata, 8'h00);

        // R9 sleep request gating, sampled within the cycle
        for (int se = 0; se < 2; se++) begin
            step(1'b1, A_MCU, se ? 8'h20 : 8'h00, 1'b0, 1'b0);
            for (int s = 0; s < 2; s++) begin
                @(negedge clk);
                bus_we = 0; sleep_op = 1'(s);
                #1;
                chk("R9 sleep_req", {7'b0, sleep_req}, 8'(se & s));
                chk("R10 no off when not live", {7'b0, bod_off}, 8'h00);
            end
        end
        step(1'b1, A_MCU, 8'h20, 1'b0, 1'b0);

        // R7 commit pattern without arming
        step(1'b1, A_BOD, 8'h02, 1'b0, 1'b0);
        chk("R7 no arm", bus_rdata, 8'h00);
        idle(8);
        chk("R7 stays clear", bus_rdata, 8'h00);

        // R4/R5/R6 window sweep: commit d cycles after arming
        for (int d = 1; d <= 6; d++) begin
            step(1'b1, A_BOD, 8'h03, 1'b0, 1'b0);
            chk("R4 armed read", bus_rdata, 8'h03);
            idle(d - 1);
            step(1'b1, A_BOD, 8'h02, 1'b0, 1'b0);
            chk((d <= 4) ? "R5 commit in window" : "R6 commit too late",
                bus_rdata, (d <= 4) ? 8'h02 : 8'h00);
            idle(10);
            chk("R8 self cleared", bus_rdata, 8'h00);
        end

        // R6 wrong second pattern inside window
        for (int p = 0; p < 4; p++) begin
            if (p == 2) continue;
            step(1'b1, A_BOD, 8'h03, 1'b0, 1'b0);
            step(1'b1, A_BOD, 8'(p), 1'b0, 1'b0);
            chk("R6 mismatch clears", bus_rdata, 8'h00);
            step(1'b1, A_BOD, 8'h02, 1'b0, 1'b0);
            chk("R6 late commit after abort", bus_rdata, 8'h00);
            idle(8);
        end

        // R8 readback timeline after commit in cycle j
        step(1'b1, A_BOD, 8'h03, 1'b0, 1'b0);
        step(1'b1, A_BOD, 8'h02, 1'b0, 1'b0);
        for (int k = 1; k <= 8; k++) begin
            chk("R8 flag timeline", bus_rdata, (k <= 6) ? 8'h02 : 8'h00);
            idle(1);
        end

        // R12 writes during pending/live are ignored
        step(1'b1, A_BOD, 8'h03, 1'b0, 1'b0);
        step(1'b1, A_BOD, 8'h02, 1'b0, 1'b0);
        step(1'b1, A_BOD, 8'h00, 1'b0, 1'b0);
        chk("R12 pending write ignored", bus_rdata, 8'h02);
        step(1'b1, A_BOD, 8'h03, 1'b0, 1'b0);
        idle(1);
        step(1'b0, A_BOD, 8'h00, 1'b1, 1'b0);
        chk("R12 live still on time", {7'b0, bod_off}, 8'h01);
        idle(3);
        chk("R12 lapse on time", bus_rdata, 8'h00);
        step(1'b0, A_BOD, 8'h00, 1'b0, 1'b1);

        // R10 sweep of sleep strobe offset o after commit
        for (int o = 1; o <= 8; o++) begin
            step(1'b1, A_BOD, 8'h03, 1'b0, 1'b0);
            step(1'b1, A_BOD, 8'h02, 1'b0, 1'b0);
            idle(o - 1);
            step(1'b0, A_BOD, 8'h00, 1'b1, 1'b0);
            chk("R10 bod_off by offset", {7'b0, bod_off}, (o >= 4 && o <= 6) ? 8'h01 : 8'h00);
            idle(6);
            chk("R11 held until wake", {7'b0, bod_off}, (o >= 4 && o <= 6) ? 8'h01 : 8'h00);
            step(1'b0, A_BOD, 8'h00, 1'b0, 1'b1);
            chk("R11 wake clears", {7'b0, bod_off}, 8'h00);
        end

        // R10 sleep disabled while live
        step(1'b1, A_MCU, 8'h00, 1'b0, 1'b0);
        step(1'b1, A_BOD, 8'h03, 1'b0, 1'b0);
        step(1'b1, A_BOD, 8'h02, 1'b0, 1'b0);
        idle(3);
        step(1'b0, A_BOD, 8'h00, 1'b1, 1'b0);
        chk("R10 sleep_en low", {7'b0, bod_off}, 8'h00);
        idle(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule